// File: doc/BRIEF.md
# Interrupt Routing Control Unit

This block collects interrupt sources from two banks of sixteen peripheral sources and steers each one onto one of five processor interrupt request lines. Each bank has a raw status word, sampled from level inputs, and an enable word written by software. A source is effective only when both its status bit and its enable bit are set.

Each routable source has a 3-bit routing code. The codes are packed into four 16-bit routing words, and each code selects the request line that the source drives. Sources with no routing field are tied to a fixed line. Software reaches every register over a simple 16-bit register bus with two address spaces, selected by `bus_sel_i`. For each line, a read-only winner register reports the highest-priority effective source on that line, so a dispatch routine can find the cause of an interrupt with a single read.

Top module: `irq_route_unit`

## Requirements
- R1: The raw inputs are registered every cycle into the status words, which read back at offset 0x00 of each space one cycle later. A bus write to a status offset has no effect.
- R2: A source is effective when its status bit and its enable bit are both 1. Enable words sit at offset 0x0C (space 0) and 0x06 (space 1). A change on a raw input reaches `cpu_irq_o` two clock edges later, and an enable write reaches it one edge later.
- R3: Bank-1 routing uses word A at space-0 offset 0x04 and word B at space-0 offset 0x06. Word A holds the codes for sources 0, 1, 2, 3 and 8 at bit offsets 0, 3, 6, 9 and 12. Word B holds the codes for sources 9, 11 and 12 at bit offsets 0, 6 and 9.
- R4: Bank-2 routing uses word C at space-0 offset 0x1C and word D at space-0 offset 0x1E. Word C holds the codes for sources 0, 1, 3, 4 and 5, and word D holds the codes for sources 6 to 10, each at bit offsets 0, 3, 6, 9 and 12.
- R5: A source without a routing field drives a fixed line. Bank-2 source 2 drives line 3. Every other such source drives line 0.
- R6: Codes 5, 6 and 7 drive no line. Routing-word bits that belong to no field (bit 15, and bits 5:3 and 14:12 of word B) do not change any output.
- R7: Synchronous reset clears the status, enable, winner and read-data registers and `cpu_irq_o`. It loads the routing words A, B, C and D with 0x0040, 0x0000, 0x0002 and 0x0000.
- R8: `cpu_irq_o[n]` is a registered output that is 1 when at least one effective source has code n.
- R9: Winner register n (n = 0 to 4) sits at space-1 offset 0x20+2n. Bit 15 is the valid flag, bit 4 is the bank (0 = bank 1), bits 3:0 are the source index, and the other bits are zero. Bank 1 wins over bank 2, and within a bank the lowest index wins. The register is updated together with `cpu_irq_o`.
- R10: A read with `bus_rd_i` loads `bus_rdata_o` at the next edge. The value holds until the next read. Unmapped or odd offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank1_raw_i | input | 16 | Level interrupt sources, bank 1 |
| bank2_raw_i | input | 16 | Level interrupt sources, bank 2 |
| bus_sel_i | input | 1 | Address space select (0 or 1) |
| bus_addr_i | input | 6 | Byte offset within the space |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| cpu_irq_o | output | 5 | Level request per processor line |

## Verification
The hardest situation to reach is a contest on one line between sources from both banks. In that case the winner register must show the bank-1 source, and must switch to the bank-2 source only once every bank-1 contender has gone. The bench first reprograms the routing words so that a bank-1 source and a bank-2 source share line 2. It then drops the bank-1 source while the bank-2 source stays active, and reads the winner register in both states. A random phase then mixes routing rewrites, enable changes and source patterns, so that illegal codes, unroutable sources and shared lines meet under the cycle-by-cycle model.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int WORD_W     = 16;
  localparam int BANK_SRC   = 16;
  localparam int CODE_W     = 3;
  localparam int ROUTE_WRDS = 4;

  // Space 0 offsets
  localparam logic [5:0] ADR_STAT_A  = 6'h00;
  localparam logic [5:0] ADR_ROUTE_A = 6'h04;
  localparam logic [5:0] ADR_ROUTE_B = 6'h06;
  localparam logic [5:0] ADR_EN_A    = 6'h0C;
  localparam logic [5:0] ADR_ROUTE_C = 6'h1C;
  localparam logic [5:0] ADR_ROUTE_D = 6'h1E;
  // Space 1 offsets
  localparam logic [5:0] ADR_STAT_B  = 6'h00;
  localparam logic [5:0] ADR_EN_B    = 6'h06;
  localparam logic [5:0] ADR_WIN0    = 6'h20;

  // Packed field location: word*WORD_W + lsb, or -1 when the source is fixed.
  function automatic int field_pos(input int bank, input int idx);
    if (bank == 0) begin
      case (idx)
        0: return 0;
        1: return 3;
        2: return 6;
        3: return 9;
        8: return 12;
        9: return WORD_W + 0;
        11: return WORD_W + 6;
        12: return WORD_W + 9;
        default: return -1;
      endcase
    end else begin
      case (idx)
        0: return 2*WORD_W + 0;
        1: return 2*WORD_W + 3;
        3: return 2*WORD_W + 6;
        4: return 2*WORD_W + 9;
        5: return 2*WORD_W + 12;
        6, 7, 8, 9, 10: return 3*WORD_W + (idx - 6) * 3;
        default: return -1;
      endcase
    end
  endfunction

  function automatic int default_code(input int bank, input int idx);
    if (bank == 0 && idx == 2) return 1;
    if (bank == 1 && idx == 0) return 2;
    if (bank == 1 && idx == 2) return 3;
    return 0;
  endfunction

  function automatic logic [WORD_W-1:0] route_reset(input int word);
    logic [WORD_W-1:0] v;
    int p;
    v = '0;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < BANK_SRC; i++) begin
        p = field_pos(b, i);
        if (p >= 0 && (p / WORD_W) == word)
          v = v | (WORD_W'(default_code(b, i)) << (p % WORD_W));
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int N_LINE = 5,
  parameter int AW     = 6,
  parameter int N_RW   = ROUTE_WRDS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [W-1:0]               raw1,
  input  logic [W-1:0]               raw2,
  input  logic                       sel,
  input  logic [AW-1:0]              addr,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [W-1:0]               wdata,
  input  logic [N_LINE-1:0][W-1:0]   win_view,
  output logic [W-1:0]               stat1,
  output logic [W-1:0]               stat2,
  output logic [W-1:0]               en1,
  output logic [W-1:0]               en2,
  output logic [N_RW-1:0][W-1:0]     route,
  output logic [W-1:0]               rdata
);
  logic [W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (!sel) begin
      case (addr)
        AW'(ADR_STAT_A):  rd_next = stat1;
        AW'(ADR_ROUTE_A): rd_next = route[0];
        AW'(ADR_ROUTE_B): rd_next = route[1];
        AW'(ADR_EN_A):    rd_next = en1;
        AW'(ADR_ROUTE_C): rd_next = route[2];
        AW'(ADR_ROUTE_D): rd_next = route[3];
        default:          rd_next = '0;
      endcase
    end else begin
      if (addr == AW'(ADR_STAT_B)) rd_next = stat2;
      if (addr == AW'(ADR_EN_B))   rd_next = en2;
      for (int l = 0; l < N_LINE; l++) begin
        if (addr == AW'(int'(ADR_WIN0) + 2*l)) rd_next = win_view[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat1 <= '0;
      stat2 <= '0;
      en1   <= '0;
      en2   <= '0;
      rdata <= '0;
      for (int k = 0; k < N_RW; k++) route[k] <= route_reset(k);
    end else begin
      stat1 <= raw1;
      stat2 <= raw2;
      if (wr) begin
        if (!sel) begin
          case (addr)
            AW'(ADR_ROUTE_A): route[0] <= wdata;
            AW'(ADR_ROUTE_B): route[1] <= wdata;
            AW'(ADR_EN_A):    en1      <= wdata;
            AW'(ADR_ROUTE_C): route[2] <= wdata;
            AW'(ADR_ROUTE_D): route[3] <= wdata;
            default: ;
          endcase
        end else if (addr == AW'(ADR_EN_B)) begin
          en2 <= wdata;
        end
      end
      if (rd) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
  import irq_route_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int N_SRC  = BANK_SRC,
  parameter int N_LINE = 5,
  parameter int CW     = CODE_W,
  parameter int N_RW   = ROUTE_WRDS
) (
  input  logic [2*N_SRC-1:0]              eff,
  input  logic [N_RW-1:0][W-1:0]          route,
  output logic [N_LINE-1:0][2*N_SRC-1:0]  req
);
  localparam int N_ALL = 2 * N_SRC;

  for (genvar g = 0; g < N_ALL; g++) begin : g_src
    localparam int POS = field_pos(g / N_SRC, g % N_SRC);
    logic [CW-1:0] code;
    if (POS >= 0) begin : g_field
      assign code = route[POS / W][(POS % W) +: CW];
    end else begin : g_fixed
      assign code = CW'(default_code(g / N_SRC, g % N_SRC));
    end
    for (genvar l = 0; l < N_LINE; l++) begin : g_line
      assign req[l][g] = eff[g] && (code == CW'(l));
    end
  end
endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick #(
  parameter int N_LINE = 5,
  parameter int N_IN   = 32,
  parameter int IDX_W  = $clog2(N_IN)
) (
  input  logic [N_LINE-1:0][N_IN-1:0]   req,
  output logic [N_LINE-1:0]             hit,
  output logic [N_LINE-1:0][IDX_W-1:0]  idx
);
  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    logic             hit_l;
    logic [IDX_W-1:0] idx_l;
    always_comb begin
      hit_l = 1'b0;
      idx_l = '0;
      for (int i = N_IN - 1; i >= 0; i--) begin
        if (req[l][i]) begin
          hit_l = 1'b1;
          idx_l = IDX_W'(i);
        end
      end
    end
    assign hit[l] = hit_l;
    assign idx[l] = idx_l;
  end
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int N_SRC  = BANK_SRC,
  parameter int N_LINE = 5,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      bank1_raw_i,
  input  logic [W-1:0]      bank2_raw_i,
  input  logic              bus_sel_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic [N_LINE-1:0] cpu_irq_o
);
  localparam int N_ALL = 2 * N_SRC;
  localparam int IDX_W = $clog2(N_ALL);

  logic [W-1:0]                 stat1_w, stat2_w, en1_w, en2_w;
  logic [ROUTE_WRDS-1:0][W-1:0] route_w;
  logic [N_ALL-1:0]             eff_w;
  logic [N_LINE-1:0][N_ALL-1:0] req_w;
  logic [N_LINE-1:0]            hit_w;
  logic [N_LINE-1:0][IDX_W-1:0] idx_w;
  logic [N_LINE-1:0][W-1:0]     win_next, win_q;

  irq_route_regs #(.W(W), .N_LINE(N_LINE), .AW(AW), .N_RW(ROUTE_WRDS)) u_regs (
    .clk(clk), .rst(rst), .raw1(bank1_raw_i), .raw2(bank2_raw_i),
    .sel(bus_sel_i), .addr(bus_addr_i), .wr(bus_wr_i), .rd(bus_rd_i),
    .wdata(bus_wdata_i), .win_view(win_q), .stat1(stat1_w), .stat2(stat2_w),
    .en1(en1_w), .en2(en2_w), .route(route_w), .rdata(bus_rdata_o)
  );

  assign eff_w = {stat2_w[N_SRC-1:0] & en2_w[N_SRC-1:0],
                  stat1_w[N_SRC-1:0] & en1_w[N_SRC-1:0]};

  irq_route_map #(.W(W), .N_SRC(N_SRC), .N_LINE(N_LINE), .CW(CODE_W),
                  .N_RW(ROUTE_WRDS)) u_map (
    .eff(eff_w), .route(route_w), .req(req_w)
  );

  irq_route_pick #(.N_LINE(N_LINE), .N_IN(N_ALL), .IDX_W(IDX_W)) u_pick (
    .req(req_w), .hit(hit_w), .idx(idx_w)
  );

  always_comb begin
    for (int l = 0; l < N_LINE; l++) begin
      win_next[l]            = '0;
      win_next[l][W-1]       = hit_w[l];
      win_next[l][IDX_W-1:0] = idx_w[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq_o <= '0;
      win_q     <= '0;
    end else begin
      for (int l = 0; l < N_LINE; l++) cpu_irq_o[l] <= |req_w[l];
      win_q <= win_next;
    end
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int W      = 16,
  parameter int N_LINE = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic [N_LINE-1:0]        irq,
  input logic [N_LINE-1:0][W-1:0] win,
  input logic [W-1:0]             en1,
  input logic [W-1:0]             en2,
  input logic [W-1:0]             stat1,
  input logic [W-1:0]             stat2,
  input logic [W-1:0]             raw1,
  input logic [W-1:0]             raw2
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R7: the cycle after a reset edge shows no request
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) a_r7_reset_quiet: assert (irq == '0);
  end

  // R1: status words track the raw inputs one cycle late
  a_r1_status_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stat1 == $past(raw1) && stat2 == $past(raw2)));

  // R2: with both enable words clear no line rises at the next edge
  a_r2_no_enable_quiet: assert property (@(posedge clk) disable iff (rst)
    (en1 == '0 && en2 == '0) |=> (irq == '0));

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    // R9: the winner valid flag and the line level agree
    a_r9_win_valid_line: assert property (@(posedge clk) disable iff (rst)
      irq[l] == win[l][W-1]);
  end
endmodule

bind irq_route_unit irq_route_chk #(.W(W), .N_LINE(N_LINE)) u_chk (
  .clk(clk), .rst(rst), .irq(cpu_irq_o), .win(win_q), .en1(en1_w),
  .en2(en2_w), .stat1(stat1_w), .stat2(stat2_w), .raw1(bank1_raw_i),
  .raw2(bank2_raw_i)
);

// File: tb/irq_route_unit_bench.sv
module irq_route_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] raw1 = '0, raw2 = '0;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0]  irq;

  always #4 clk = ~clk;

  irq_route_unit u_irq_route_unit (
    .clk(clk), .rst(rst), .bank1_raw_i(raw1), .bank2_raw_i(raw2),
    .bus_sel_i(sel), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R7";
  bit    done = 0;

  // Behavioural reference state
  logic [15:0] m_stat1, m_stat2, m_en1, m_en2, m_rd;
  logic [15:0] m_rt [4];
  logic [4:0]  m_irq;
  logic [15:0] m_win [5];

  function automatic int code_of(int bank, int idx);
    int w, p;
    w = -1; p = 0;
    if (bank == 0) begin
      if (idx <= 3)       begin w = 0; p = idx * 3; end
      else if (idx == 8)  begin w = 0; p = 12; end
      else if (idx == 9)  begin w = 1; p = 0; end
      else if (idx == 11) begin w = 1; p = 6; end
      else if (idx == 12) begin w = 1; p = 9; end
    end else begin
      if (idx == 2) return 3;
      if (idx <= 1)                   begin w = 2; p = idx * 3; end
      else if (idx >= 3 && idx <= 5)  begin w = 2; p = (idx - 1) * 3; end
      else if (idx >= 6 && idx <= 10) begin w = 3; p = (idx - 6) * 3; end
    end
    if (w < 0) return 0;
    return int'((m_rt[w] >> p) & 16'h7);
  endfunction

  function automatic logic [15:0] read_val(logic s, logic [5:0] a);
    if (!s) begin
      if (a == 6'h00) return m_stat1;
      if (a == 6'h04) return m_rt[0];
      if (a == 6'h06) return m_rt[1];
      if (a == 6'h0C) return m_en1;
      if (a == 6'h1C) return m_rt[2];
      if (a == 6'h1E) return m_rt[3];
    end else begin
      if (a == 6'h00) return m_stat2;
      if (a == 6'h06) return m_en2;
      if (a >= 6'h20 && a <= 6'h28 && !a[0]) return m_win[(a - 6'h20) >> 1];
    end
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    logic [4:0]  nirq;
    logic [15:0] nwin [5];
    logic [15:0] nrd;
    logic [15:0] e;
    if (rst) begin
      m_stat1 = 0; m_stat2 = 0; m_en1 = 0; m_en2 = 0; m_rd = 0; m_irq = 0;
      m_rt[0] = 16'h0040; m_rt[1] = 16'h0000; m_rt[2] = 16'h0002; m_rt[3] = 16'h0000;
      for (int l = 0; l < 5; l++) m_win[l] = 0;
    end else begin
      for (int l = 0; l < 5; l++) begin
        nirq[l] = 1'b0;
        nwin[l] = 16'h0000;
        for (int b = 0; b < 2; b++) begin
          e = (b == 0) ? (m_stat1 & m_en1) : (m_stat2 & m_en2);
          for (int i = 0; i < 16; i++) begin
            if (!nirq[l] && e[i] && code_of(b, i) == l) begin
              nirq[l] = 1'b1;
              nwin[l] = 16'h8000 | 16'(b * 16 + i);
            end
          end
        end
      end
      nrd = rd ? read_val(sel, addr) : m_rd;
      if (wr) begin
        if (!sel) begin
          case (addr)
            6'h04: m_rt[0] = wdata;
            6'h06: m_rt[1] = wdata;
            6'h0C: m_en1   = wdata;
            6'h1C: m_rt[2] = wdata;
            6'h1E: m_rt[3] = wdata;
            default: ;
          endcase
        end else if (addr == 6'h06) m_en2 = wdata;
      end
      m_stat1 = raw1; m_stat2 = raw2;
      m_irq = nirq; m_rd = nrd;
      for (int l = 0; l < 5; l++) m_win[l] = nwin[l];
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (irq !== m_irq) begin
        n_fail++;
        $display("FAIL %s cpu_irq_o actual=%b expected=%b at %0t", cur_req, irq, m_irq, $time);
      end
      n_chk++;
      if (rdata !== m_rd) begin
        n_fail++;
        $display("FAIL %s bus_rdata_o actual=%h expected=%h at %0t", cur_req, rdata, m_rd, $time);
      end
    end
  end

  task automatic bus_write(logic s, logic [5:0] a, logic [15:0] d);
    @(negedge clk); sel = s; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic expect_read(logic s, logic [5:0] a, logic [15:0] exp, string r);
    @(negedge clk); sel = s; addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read %0d:%h actual=%h expected=%h", r, s, a, rdata, exp);
    end
  endtask

  task automatic expect_irq(logic [4:0] exp, string r);
    repeat (3) @(negedge clk);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s cpu_irq_o actual=%b expected=%b", r, irq, exp);
    end
  endtask

  task automatic set_raw(logic [15:0] a, logic [15:0] b);
    @(negedge clk); raw1 = a; raw2 = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset contents
    cur_req = "R7";
    expect_irq(5'b00000, "R7");
    expect_read(0, 6'h04, 16'h0040, "R7");
    expect_read(0, 6'h06, 16'h0000, "R7");
    expect_read(0, 6'h1C, 16'h0002, "R7");
    expect_read(0, 6'h1E, 16'h0000, "R7");
    expect_read(0, 6'h0C, 16'h0000, "R7");
    expect_read(1, 6'h06, 16'h0000, "R7");
    // R1 status sampling, writes ignored
    cur_req = "R1";
    set_raw(16'h0005, 16'h0000);
    expect_irq(5'b00000, "R1");
    expect_read(0, 6'h00, 16'h0005, "R1");
    bus_write(0, 6'h00, 16'hFFFF);
    expect_read(0, 6'h00, 16'h0005, "R1");
    // R2 enable gating with default routing
    cur_req = "R2";
    bus_write(0, 6'h0C, 16'hFFFF);
    expect_irq(5'b00011, "R2");
    // R3 bank-1 field layout
    cur_req = "R3";
    bus_write(0, 6'h04, 16'h145C);
    set_raw(16'h000F, 16'h0000);
    expect_irq(5'b11110, "R3");
    bus_write(0, 6'h06, 16'h0681);
    set_raw(16'h1A00, 16'h0000);
    expect_irq(5'b01110, "R3");
    // R5 fixed bank-1 source 10, R6 gap bits in word B
    cur_req = "R6";
    bus_write(0, 6'h06, 16'h06B9);
    set_raw(16'h1E00, 16'h0000);
    expect_irq(5'b01111, "R5");
    // R4 bank-2 layout
    cur_req = "R4";
    bus_write(1, 6'h06, 16'hFFFF);
    bus_write(0, 6'h1C, 16'h3044);
    bus_write(0, 6'h1E, 16'h2001);
    set_raw(16'h0000, 16'h0469);
    expect_irq(5'b11110, "R4");
    cur_req = "R5";
    set_raw(16'h0000, 16'h1004);
    expect_irq(5'b01001, "R5");
    // R6 illegal codes and bit 15
    cur_req = "R6";
    bus_write(0, 6'h04, 16'h8007);
    set_raw(16'h0001, 16'h0000);
    expect_irq(5'b00000, "R6");
    set_raw(16'h0003, 16'h0000);
    expect_irq(5'b00001, "R6");
    bus_write(0, 6'h04, 16'h0035);
    expect_irq(5'b00000, "R6");
    // R9 priority and winner format
    cur_req = "R9";
    bus_write(0, 6'h04, 16'h0400);
    bus_write(0, 6'h1C, 16'h0002);
    set_raw(16'h0008, 16'h0001);
    expect_irq(5'b00100, "R8");
    expect_read(1, 6'h24, 16'h8003, "R9");
    expect_read(1, 6'h20, 16'h0000, "R9");
    set_raw(16'h0000, 16'h0001);
    expect_irq(5'b00100, "R8");
    expect_read(1, 6'h24, 16'h8010, "R9");
    set_raw(16'h0103, 16'h0000);
    expect_irq(5'b00001, "R8");
    expect_read(1, 6'h20, 16'h8000, "R9");
    set_raw(16'h0102, 16'h0000);
    expect_irq(5'b00001, "R8");
    expect_read(1, 6'h20, 16'h8001, "R9");
    // R10 unmapped and odd reads
    cur_req = "R10";
    expect_read(0, 6'h02, 16'h0000, "R10");
    expect_read(1, 6'h2A, 16'h0000, "R10");
    expect_read(1, 6'h21, 16'h0000, "R10");
    // Random mix under the model
    cur_req = "R8";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      raw1 = 16'($urandom); raw2 = 16'($urandom);
      wr = 1'b0; rd = 1'b0;
      case ($urandom % 4)
        0: begin
          wr = 1'b1; sel = 1'($urandom);
          addr = {2'b00, 4'($urandom)} << 1;
          wdata = 16'($urandom);
        end
        1: begin
          rd = 1'b1; sel = 1'($urandom);
          addr = 6'($urandom);
        end
        default: ;
      endcase
    end
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule